// File: doc/BRIEF.md
# Approximate Logarithmic Multiplier with Region Compensation

This block multiplies two unsigned 8-bit operands approximately, working through base-2 logarithms. Each operand is encoded as the position of its leading one (the integer part of its log) and the bits under that one, left-aligned as a 7-bit fraction. The two log values are added. A truncating adder forms the fraction sum and never computes the lowest `K` bits of either fraction. A non-negative correction, in units of one fraction LSB, is added to the log sum. The antilog step then rebuilds the product as `1.fraction` shifted by the integer part, which gives a 16-bit result.

The correction comes from one of three sources, picked per operation by a 2-bit mode input. It can be a 16-entry table indexed by the operand-pair region, a single constant used for every product, or nothing at all (plain logarithmic multiplication). The table depends on `K`, so every truncation width has its own coefficient set. The datapath is combinational up to one output register. A result comes out one clock after its input strobe.

Top module: `alm_mul`

## Requirements
- R1: If either operand is zero, the product is exactly 0 in every mode.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `in_valid` is low, `product` keeps its last value.
- R3: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and `product` = 0.
- R4: With correction off, a product of two powers of two is exact.
- R5: For a nonzero operand, the characteristic is the index of its highest set bit. The fraction is the bits below that bit, shifted so that the bit just under the leading one lands at fraction bit 6. The fraction sum is `((fa >> K) + (fb >> K)) << K`, with K = 3 by default.
- R6: Table mode adds `c(ra, rb) + 2^(K-1)`, where `ra = fa[6:5]` and `rb = fb[6:5]`. Let `x = 2ra+1` and `y = 2rb+1`. Then `c` is `2xy` when `x+y < 8` and `(8-x)(8-y)` otherwise.
- R7: Single mode adds `7 + 2^(K-1)` to every nonzero product. The 7 is the floor of the mean of the 16 values of `c`.
- R8: With log sum `T = 128(ka+kb) + fraction sum + correction`, the product is `floor((128 + T mod 128) * 2^(T div 128) / 128)`. Values above 65535 saturate to 65535.
- R9: Mode encoding: 0 means no correction, 1 means region table, 2 means single constant. Code 3 behaves exactly like code 0.
- R10: Over all 65,536 operand pairs, the mean relative error against the exact product is lower in table mode than with correction off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| opnd_a | input | 8 | First unsigned operand |
| opnd_b | input | 8 | Second unsigned operand |
| mode | input | 2 | Correction source: 0 off, 1 table, 2 single, 3 off |
| out_valid | output | 1 | Product register updated from the previous cycle |
| product | output | 16 | Approximate unsigned product |

## Verification
All state sits in the single output register. A wrong value there shows at the ports one clock after the strobe that loaded it, and it stays visible until the next strobe. A wrong leading-one position or fraction alignment shifts or scales the product by a power of two. A wrong truncation width or a wrong table entry shifts the fraction by a few LSBs, and only in some operand regions. These faults are therefore found by the exhaustive sweep against an independent bit-accurate model rather than by spot values. A valid or hold fault shows in the first idle cycle after a strobe.

// File: rtl/alm_pkg.sv
// Shared types and elaboration-time coefficient arithmetic for the
// approximate logarithmic multiplier. Assumes a 7-bit fraction scale and
// 2-bit regions per operand (16 regions in total).
package alm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_TABLE  = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } alm_mode_e;

    localparam int REGION_BITS = 2;
    localparam int REGION_CNT  = 1 << (2 * REGION_BITS);

    // Mean approximation error at the region centre, in fraction LSBs.
    function automatic int region_base(input int ra, input int rb);
        if (ra + rb < 3)
            return 2 * (2 * ra + 1) * (2 * rb + 1);
        else
            return (7 - 2 * ra) * (7 - 2 * rb);
    endfunction

    // Per-region coefficient, biased by half the dropped truncation span.
    function automatic int region_coef(input int ra, input int rb, input int k);
        return region_base(ra, rb) + (1 << (k - 1));
    endfunction

    // Single coefficient: floor of the mean base value plus the same bias.
    function automatic int single_coef(input int k);
        int acc;
        acc = 0;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                acc += region_base(i, j);
        return acc / REGION_CNT + (1 << (k - 1));
    endfunction

endpackage

// File: rtl/alm_log_enc.sv
// Log encoder: finds the leading one of an operand (characteristic) and
// returns the fraction bits below it, left-aligned, with the lowest K bits
// already dropped. A zero operand yields characteristic 0 and fraction 0;
// the caller handles zero separately.
module alm_log_enc #(
    parameter int W = 8,
    parameter int K = 3
) (
    input  logic [W-1:0]             opnd,
    output logic [$clog2(W)-1:0]     charac,
    output logic [W-2-K:0]           frac_hi
);
    localparam int CW = $clog2(W);
    localparam int FW = W - 1;
    localparam int FH = FW - K;

    // Priority scan: the highest set bit wins.
    always_comb begin
        charac = '0;
        for (int i = 0; i < W; i++)
            if (opnd[i]) charac = CW'(i);
    end

    // Align the leading one to the top bit, then keep the kept fraction bits.
    always_comb frac_hi = FH'((opnd << (CW'(FW) - charac)) >> K);

endmodule

// File: rtl/alm_comp.sv
// Compensation selector: returns the correction in fraction LSBs for the
// chosen mode. The region table is filled at elaboration from the package
// formula for the configured truncation width K.
module alm_comp #(
    parameter int K   = 3,
    parameter int CRW = 6
) (
    input  logic [1:0]                       mode,
    input  logic [alm_pkg::REGION_BITS-1:0]  reg_a,
    input  logic [alm_pkg::REGION_BITS-1:0]  reg_b,
    output logic [CRW-1:0]                   corr
);
    import alm_pkg::*;

    localparam int              RC     = REGION_CNT;
    localparam logic [CRW-1:0]  SINGLE = CRW'(single_coef(K));

    logic [CRW-1:0] tbl [RC];

    for (genvar g = 0; g < RC; g++) begin : g_tbl
        assign tbl[g] = CRW'(region_coef(g / 4, g % 4, K));
    end

    // Mode decode: table, constant or none (codes 0 and 3).
    always_comb begin
        case (alm_mode_e'(mode))
            MODE_TABLE:  corr = tbl[{reg_a, reg_b}];
            MODE_SINGLE: corr = SINGLE;
            default:     corr = '0;
        endcase
    end

endmodule

// File: rtl/alm_antilog.sv
// Antilog stage: rebuilds 1.fraction, shifts it by the integer part of the
// log sum, drops the fraction scale and saturates to the product width.
module alm_antilog #(
    parameter int W  = 8,
    parameter int IW = 5
) (
    input  logic [IW+W-2:0]  logsum,
    output logic [2*W-1:0]   prod
);
    localparam int FW = W - 1;
    localparam int PW = FW + 1 + (1 << IW);

    logic [IW-1:0] ipart;
    logic [FW-1:0] fpart;
    logic [PW-1:0] wide;

    // Split the log sum into its integer and fraction fields.
    always_comb {ipart, fpart} = logsum;

    // Scale 1.fraction by 2^ipart and remove the fraction weight.
    always_comb wide = (PW'({1'b1, fpart}) << ipart) >> FW;

    // Saturate when the result exceeds the output width.
    always_comb prod = (|wide[PW-1:2*W]) ? '1 : wide[2*W-1:0];

endmodule

// File: rtl/alm_mul.sv
// Approximate unsigned logarithmic multiplier, top level. Combinational log
// encode, truncating fraction add, compensation and antilog, then one
// output register. Assumes W = 8 (the table formula uses a 7-bit fraction)
// and 2 <= K <= FW - 2, so that the region bits survive truncation.
module alm_mul #(
    parameter int W   = 8,
    parameter int K   = 3,
    parameter int CRW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [1:0]       mode,
    output logic             out_valid,
    output logic [2*W-1:0]   product
);
    localparam int CW = $clog2(W);
    localparam int FW = W - 1;
    localparam int FH = FW - K;
    localparam int IW = $clog2(2 * W) + 1;
    localparam int TW = IW + FW;
    localparam int RB = alm_pkg::REGION_BITS;

    logic [CW-1:0]    char_a, char_b;
    logic [FH-1:0]    frac_a, frac_b;
    logic [FH:0]      hi_sum;
    logic [CRW-1:0]   corr;
    logic [TW-1:0]    logsum;
    logic [2*W-1:0]   prod_c;
    logic             both_nz;

    alm_log_enc #(.W(W), .K(K)) u_enc_a (.opnd(opnd_a), .charac(char_a), .frac_hi(frac_a));
    alm_log_enc #(.W(W), .K(K)) u_enc_b (.opnd(opnd_b), .charac(char_b), .frac_hi(frac_b));

    alm_comp #(.K(K), .CRW(CRW)) u_comp (
        .mode  (mode),
        .reg_a (frac_a[FH-1 -: RB]),
        .reg_b (frac_b[FH-1 -: RB]),
        .corr  (corr)
    );

    // Truncating adder: only the kept fraction bits are summed.
    always_comb hi_sum = (FH+1)'(frac_a) + (FH+1)'(frac_b);

    // Full log sum: characteristics, re-weighted fraction sum, correction.
    always_comb logsum = (TW'(char_a) << FW) + (TW'(char_b) << FW)
                       + (TW'(hi_sum) << K) + TW'(corr);

    alm_antilog #(.W(W), .IW(IW)) u_alog (.logsum(logsum), .prod(prod_c));

    // Zero detect bypasses the log path entirely.
    always_comb both_nz = (|opnd_a) && (|opnd_b);

    // Output register: valid follows the strobe, product loads on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                product <= both_nz ? prod_c : '0;
        end
    end

endmodule

// File: rtl/alm_mul_chk.sv
// Checker for alm_mul: port-level timing, zero, reset and exactness rules.
// Attached to every alm_mul instance by the bind below.
module alm_mul_chk #(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W-1:0]     opnd_a,
    input logic [W-1:0]     opnd_b,
    input logic [1:0]       mode,
    input logic             out_valid,
    input logic [2*W-1:0]   product
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(product)));

    p_zero_operand_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opnd_a == '0 || opnd_b == '0)) |=> (product == '0));

    p_pow2_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 2'd0 || mode == 2'd3)
         && $countones(opnd_a) == 1 && $countones(opnd_b) == 1)
        |=> (product == (2*W)'($past(opnd_a)) * (2*W)'($past(opnd_b))));

    p_reset_state_r3: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));

endmodule

bind alm_mul alm_mul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .mode      (mode),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/tb_alm_mul.sv
// Directed bench for alm_mul: one task per scenario, exhaustive sweeps
// against an independent reference model, error statistics per mode.
module tb_alm_mul;
    localparam int K = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic [1:0]  mode = '0;
    logic        out_valid;
    logic [15:0] product;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    real mean_off, mean_tab, mean_one;

    always #5 clk = ~clk;

    alm_mul #(.W(8), .K(K), .CRW(6)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .mode(mode),
        .out_valid(out_valid), .product(product)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Correction in fraction LSBs from the requirement text (R6, R7, R9).
    function automatic int corr_of(input int fa, input int fb, input int md);
        int x, y, c;
        if (md == 2) return 7 + (1 << (K - 1));
        if (md != 1) return 0;
        x = 2 * (fa / 32) + 1;
        y = 2 * (fb / 32) + 1;
        c = (x + y < 8) ? 2 * x * y : (8 - x) * (8 - y);
        return c + (1 << (K - 1));
    endfunction

    // Bit-accurate reference built from R1, R5, R8.
    function automatic int ref_prod(input int a, input int b, input int md);
        int ka, kb, fa, fb, t, ip, fp;
        longint w;
        if (a == 0 || b == 0) return 0;
        ka = 0; while ((a >> (ka + 1)) != 0) ka++;
        kb = 0; while ((b >> (kb + 1)) != 0) kb++;
        fa = (a - (1 << ka)) << (7 - ka);
        fb = (b - (1 << kb)) << (7 - kb);
        t  = 128 * (ka + kb) + (((fa >> K) + (fb >> K)) << K) + corr_of(fa, fb, md);
        ip = t / 128;
        fp = t % 128;
        w  = (longint'(128 + fp) << ip) / 128;
        return (w > 65535) ? 65535 : int'(w);
    endfunction

    // One isolated operation: strobe for one cycle, return the result.
    task automatic one_op(input int a, input int b, input int md, output int res);
        @(negedge clk);
        in_valid = 1'b1; opnd_a = 8'(a); opnd_b = 8'(b); mode = 2'(md);
        @(negedge clk);
        in_valid = 1'b0;
        res = int'(product);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; opnd_a = 8'd200; opnd_b = 8'd99; mode = 2'd1;
        repeat (3) @(negedge clk);
        chk("R3 out_valid in reset", 32'(out_valid), 0);
        chk("R3 product in reset", 32'(product), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 out_valid after release", 32'(out_valid), 0);
    endtask

    task automatic t_valid_timing();
        int exp5x6;
        exp5x6 = ref_prod(5, 6, 0);
        @(negedge clk);
        in_valid = 1'b1; opnd_a = 8'd5; opnd_b = 8'd6; mode = 2'd0;
        @(negedge clk);
        chk("R2 out_valid one cycle later", 32'(out_valid), 1);
        chk("R2 product 5x6 off", 32'(product), 32'(exp5x6));
        chk("R8 5x6 off spot value", 32'(product), 28);
        in_valid = 1'b0; opnd_a = 8'd255; opnd_b = 8'd255; mode = 2'd2;
        @(negedge clk);
        chk("R2 out_valid drops", 32'(out_valid), 0);
        chk("R2 product held", 32'(product), 28);
        repeat (3) @(negedge clk);
        chk("R2 product held while idle", 32'(product), 28);
    endtask

    task automatic t_zero();
        int r;
        for (int md = 0; md < 4; md++) begin
            one_op(0, 0, md, r);   chk("R1 0x0", 32'(r), 0);
            one_op(0, 255, md, r); chk("R1 0x255", 32'(r), 0);
            one_op(200, 0, md, r); chk("R1 200x0", 32'(r), 0);
        end
    endtask

    task automatic t_pow2();
        int r;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                one_op(1 << i, 1 << j, 0, r);
                chk("R4 power-of-two exact", 32'(r), 32'(1 << (i + j)));
            end
    endtask

    task automatic t_known();
        int r;
        one_op(255, 255, 0, r); chk("R5 truncated sum 255x255 off", 32'(r), 61440);
        one_op(3, 3, 0, r);     chk("R5 leading one 3x3 off", 32'(r), 8);
        one_op(255, 255, 1, r); chk("R6 table 255x255", 32'(r), 62720);
        one_op(128, 128, 1, r); chk("R6 table 128x128", 32'(r), 17152);
        one_op(255, 255, 2, r); chk("R7 single 255x255", 32'(r), 64256);
        one_op(128, 128, 2, r); chk("R7 single 128x128", 32'(r), 17792);
        one_op(255, 255, 3, r); chk("R9 code 3 as off 255x255", 32'(r), 61440);
        one_op(5, 6, 3, r);     chk("R9 code 3 as off 5x6", 32'(r), 28);
        one_op(64, 32, 3, r);   chk("R9 code 3 pow2", 32'(r), 2048);
    endtask

    // Streamed sweep: a new pair every cycle, checked one cycle later.
    task automatic t_sweep(input int md, input int step, output real mean_rel);
        int  pa, pb, pexp;
        bit  have;
        real acc, peak, e;
        int  n;
        have = 1'b0; acc = 0.0; peak = 0.0; n = 0; pa = 0; pb = 0; pexp = 0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += step) begin
                @(negedge clk);
                if (have) begin
                    chk("R8 sweep vs model", 32'(product), 32'(pexp));
                    if (pa != 0 && pb != 0) begin
                        e = (real'(product) - real'(pa * pb)) / real'(pa * pb);
                        if (e < 0.0) e = -e;
                        acc += e; n++;
                        if (e > peak) peak = e;
                    end
                end
                in_valid = 1'b1; opnd_a = 8'(a); opnd_b = 8'(b); mode = 2'(md);
                pa = a; pb = b; pexp = ref_prod(a, b, md); have = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 sweep last pair", 32'(product), 32'(pexp));
        mean_rel = (n > 0) ? acc / n : 0.0;
        $display("mode %0d: mean rel err %f peak rel err %f over %0d pairs", md, mean_rel, peak, n);
    endtask

    task automatic t_error_compare();
        chk("R10 table beats plain mean error", 32'(mean_tab < mean_off), 1);
    endtask

    initial begin
        t_reset();
        t_valid_timing();
        t_zero();
        t_pow2();
        t_known();
        t_sweep(0, 1, mean_off);
        t_sweep(1, 1, mean_tab);
        t_sweep(2, 7, mean_one);
        t_error_compare();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule